// File: doc/BRIEF.md
# Coprocessor-0 Statistics and Host Register Bank

This block sits beside a processor core as its set-0 coprocessor bank: 32 slots selected by a 5-bit index. Every register reference from the core carries a type bit; only references with the type bit set to coprocessor reach this bank. The core reads the bank through a combinational read port and writes it through a write port with a ready signal. Each accepted write, of either type, also marks one completed instruction.

Three slots are live. Index 10 reads a free-running cycle counter. Index 11 reads the count of completed instructions. Index 21 holds the program result word. A start command from the host latches the initial PC for the core, clears both counters and sets the core running. Every accepted coprocessor-type write is handed to the host as an (index, data) pair through a small valid/ready queue. While that queue is full, coprocessor-type writes stall.

Top module: `cop0_stat_bank`

## Requirements
- R1: After reset, core_run is 0, to_host_valid is 0, wr_ready is 1, and coprocessor reads of indices 10, 11 and 21 return 0.
- R2: A cycle with host_start high sets core_run to 1 from the next cycle on and presents host_start_pc on core_start_pc from the next cycle; core_run then stays 1.
- R3: A coprocessor read of index 10 returns the number of clock edges seen while running since the last edge at which host_start was sampled (0 right after that edge); before the first start it reads 0.
- R4: A coprocessor read of index 11 returns the number of writes accepted (wr_valid and wr_ready, either type) since reset or the last start; a start clears it and takes priority over a write in the same cycle.
- R5: An accepted coprocessor-type write to index 21 stores wr_data, which a coprocessor read of index 21 then returns; writes to indices 10 and 11 do not change the counters beyond the completion count.
- R6: A read with rd_is_cop low, or a coprocessor read of any index other than 10, 11 and 21, returns 0.
- R7: Every accepted coprocessor-type write appears on to_host_idx/to_host_data in acceptance order; writes with wr_is_cop low are never sent.
- R8: The host queue holds QUEUE_DEPTH (default 2) pairs; with the queue full, wr_ready is 0 while wr_is_cop is 1. With wr_is_cop low, wr_ready is always 1.
- R9: While to_host_valid is 1 and to_host_ready is 0, the presented pair stays unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_start | input | 1 | Start command from host, one cycle |
| host_start_pc | input | 32 | Initial PC carried by the start command |
| core_run | output | 1 | Core is allowed to execute |
| core_start_pc | output | 32 | Latched initial PC for the core |
| rd_is_cop | input | 1 | Read reference type: 1 = coprocessor bank |
| rd_idx | input | 5 | Read register index |
| rd_data | output | 32 | Read data |
| wr_valid | input | 1 | Write/completion request from the core |
| wr_is_cop | input | 1 | Write reference type: 1 = coprocessor bank |
| wr_idx | input | 5 | Write register index |
| wr_data | input | 32 | Write data |
| wr_ready | output | 1 | Write accepted this cycle when high with wr_valid |
| to_host_valid | output | 1 | Host pair available |
| to_host_ready | input | 1 | Host takes the pair |
| to_host_idx | output | 5 | Index of the oldest queued write |
| to_host_data | output | 32 | Data of the oldest queued write |

## Verification
The hardest state to reach is a full host queue with a coprocessor write waiting, especially while the host pops in the same cycle and a normal-type write must still pass. The random stimulus holds to_host_ready low for long stretches and biases writes toward the coprocessor type, and a directed burst of three coprocessor writes with the host stalled forces the stall deterministically. Restarts are injected mid-run so that counter clearing collides with accepted writes.

// File: rtl/cop0_stat_pkg.sv
package cop0_stat_pkg;
  localparam int unsigned IDX_W  = 5;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned MSG_W  = IDX_W + DATA_W;

  typedef logic [IDX_W-1:0]  reg_idx_t;
  typedef logic [DATA_W-1:0] word_t;

  typedef struct packed {
    reg_idx_t idx;
    word_t    data;
  } host_msg_t;

  localparam reg_idx_t SLOT_CYCLES = 5'd10;
  localparam reg_idx_t SLOT_INSTRS = 5'd11;
  localparam reg_idx_t SLOT_RESULT = 5'd21;
endpackage

// File: rtl/cop0_event_counter.sv
module cop0_event_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] value
);
  logic [W-1:0] value_d;
  logic         value_en;

  always_comb begin
    value_en = clr | inc;
    value_d  = clr ? '0 : value + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        value <= '0;
    else if (value_en) value <= value_d;
  end
endmodule

// File: rtl/cop0_msg_queue.sv
module cop0_msg_queue #(
  parameter int unsigned DEPTH = 2,
  parameter int unsigned W     = 37
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         full,
  input  logic         pop,
  output logic         head_valid,
  output logic [W-1:0] head_data
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);

  logic [W-1:0]     slots [DEPTH];
  logic [PTR_W-1:0] wr_ptr, wr_ptr_d, rd_ptr, rd_ptr_d;
  logic [CNT_W-1:0] count, count_d;
  logic             push_ok, pop_ok;

  assign full       = (count == FULL_CNT);
  assign head_valid = (count != '0);
  assign head_data  = slots[rd_ptr];

  always_comb begin
    push_ok  = push & ~full;
    pop_ok   = pop & head_valid;
    wr_ptr_d = wr_ptr;
    rd_ptr_d = rd_ptr;
    count_d  = count;
    if (push_ok) wr_ptr_d = (wr_ptr == LAST_SLOT) ? '0 : wr_ptr + 1'b1;
    if (pop_ok)  rd_ptr_d = (rd_ptr == LAST_SLOT) ? '0 : rd_ptr + 1'b1;
    case ({push_ok, pop_ok})
      2'b10:   count_d = count + 1'b1;
      2'b01:   count_d = count - 1'b1;
      default: count_d = count;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_d;
      rd_ptr <= rd_ptr_d;
      count  <= count_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push_ok && (wr_ptr == PTR_W'(g))) slots[g] <= push_data;
    end
  end
endmodule

// File: rtl/cop0_stat_bank.sv
module cop0_stat_bank
  import cop0_stat_pkg::*;
#(
  parameter int unsigned QUEUE_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_start,
  input  logic [DATA_W-1:0] host_start_pc,
  output logic              core_run,
  output logic [DATA_W-1:0] core_start_pc,
  input  logic              rd_is_cop,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_valid,
  input  logic              wr_is_cop,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  output logic              to_host_valid,
  input  logic              to_host_ready,
  output logic [IDX_W-1:0]  to_host_idx,
  output logic [DATA_W-1:0] to_host_data
);
  logic        q_full;
  logic        accept, push;
  host_msg_t   push_msg, head_msg;
  word_t       cyc_cnt, ins_cnt;
  word_t       result_q, result_d;
  logic        result_en;
  logic        run_d;

  // Write handshake: only coprocessor writes need queue space.
  always_comb begin
    wr_ready      = ~(wr_is_cop & q_full);
    accept        = wr_valid & wr_ready;
    push          = accept & wr_is_cop;
    push_msg.idx  = wr_idx;
    push_msg.data = wr_data;
  end

  cop0_msg_queue #(
    .DEPTH (QUEUE_DEPTH),
    .W     (MSG_W)
  ) host_q_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (push),
    .push_data  (push_msg),
    .full       (q_full),
    .pop        (to_host_ready),
    .head_valid (to_host_valid),
    .head_data  (head_msg)
  );

  assign to_host_idx  = head_msg.idx;
  assign to_host_data = head_msg.data;

  cop0_event_counter #(.W(DATA_W)) cyc_ctr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (host_start),
    .inc   (core_run),
    .value (cyc_cnt)
  );

  cop0_event_counter #(.W(DATA_W)) ins_ctr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (host_start),
    .inc   (accept),
    .value (ins_cnt)
  );

  // Run flag, start PC and result register next-state.
  always_comb begin
    run_d     = core_run | host_start;
    result_en = push & (wr_idx == SLOT_RESULT);
    result_d  = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_run      <= 1'b0;
      core_start_pc <= '0;
      result_q      <= '0;
    end else begin
      core_run <= run_d;
      if (host_start) core_start_pc <= host_start_pc;
      if (result_en)  result_q      <= result_d;
    end
  end

  // Read mux: normal-type references and unused slots read zero.
  always_comb begin
    rd_data = '0;
    if (rd_is_cop) begin
      case (rd_idx)
        SLOT_CYCLES: rd_data = cyc_cnt;
        SLOT_INSTRS: rd_data = ins_cnt;
        SLOT_RESULT: rd_data = result_q;
        default:     rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/cop0_stat_bank_chk.sv
module cop0_stat_bank_chk #(
  parameter int unsigned QUEUE_DEPTH = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        host_start,
  input logic [31:0] host_start_pc,
  input logic        core_run,
  input logic [31:0] core_start_pc,
  input logic        wr_valid,
  input logic        wr_is_cop,
  input logic        wr_ready,
  input logic        to_host_valid,
  input logic        to_host_ready,
  input logic [4:0]  to_host_idx,
  input logic [31:0] to_host_data
);
  logic [7:0] occ;
  logic       c_push, c_pop;

  assign c_push = wr_valid & wr_ready & wr_is_cop;
  assign c_pop  = to_host_valid & to_host_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ <= '0;
    else        occ <= occ + {7'd0, c_push} - {7'd0, c_pop};
  end

  a_r8_stall_at_capacity: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_is_cop && occ == 8'(QUEUE_DEPTH)) |-> !wr_ready);

  a_r8_normal_never_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_is_cop |-> wr_ready);

  a_r7_valid_tracks_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (occ != 8'd0) == to_host_valid);

  a_r9_hold_when_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (to_host_valid && !to_host_ready) |=>
      (to_host_valid && $stable(to_host_idx) && $stable(to_host_data)));

  a_r2_start_latches_pc: assert property (@(posedge clk) disable iff (!rst_n)
    host_start |=> (core_run && core_start_pc == $past(host_start_pc)));

  a_r2_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    core_run |=> core_run);
endmodule

bind cop0_stat_bank cop0_stat_bank_chk #(.QUEUE_DEPTH(QUEUE_DEPTH)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .host_start    (host_start),
  .host_start_pc (host_start_pc),
  .core_run      (core_run),
  .core_start_pc (core_start_pc),
  .wr_valid      (wr_valid),
  .wr_is_cop     (wr_is_cop),
  .wr_ready      (wr_ready),
  .to_host_valid (to_host_valid),
  .to_host_ready (to_host_ready),
  .to_host_idx   (to_host_idx),
  .to_host_data  (to_host_data)
);

// File: tb/cop0_stat_bank_tb_top.sv
`timescale 1ns/1ps
module cop0_stat_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_start;
  logic [31:0] host_start_pc;
  logic        core_run;
  logic [31:0] core_start_pc;
  logic        rd_is_cop;
  logic [4:0]  rd_idx;
  logic [31:0] rd_data;
  logic        wr_valid, wr_is_cop;
  logic [4:0]  wr_idx;
  logic [31:0] wr_data;
  logic        wr_ready;
  logic        to_host_valid, to_host_ready;
  logic [4:0]  to_host_idx;
  logic [31:0] to_host_data;

  always #2.5 clk = ~clk;

  cop0_stat_bank dut_i (
    .clk(clk), .rst_n(rst_n),
    .host_start(host_start), .host_start_pc(host_start_pc),
    .core_run(core_run), .core_start_pc(core_start_pc),
    .rd_is_cop(rd_is_cop), .rd_idx(rd_idx), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_is_cop(wr_is_cop), .wr_idx(wr_idx),
    .wr_data(wr_data), .wr_ready(wr_ready),
    .to_host_valid(to_host_valid), .to_host_ready(to_host_ready),
    .to_host_idx(to_host_idx), .to_host_data(to_host_data)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference model state
  bit          m_run;
  logic [31:0] m_pc, m_cyc, m_ins, m_res;
  logic [36:0] m_q[$];

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(logic is_cop, logic [4:0] idx);
    if (!is_cop)      return 32'd0;
    if (idx == 5'd10) return m_cyc;
    if (idx == 5'd11) return m_ins;
    if (idx == 5'd21) return m_res;
    return 32'd0;
  endfunction

  function automatic string read_req(logic is_cop, logic [4:0] idx);
    if (!is_cop)      return "R6";
    if (idx == 5'd10) return "R3";
    if (idx == 5'd11) return "R4";
    if (idx == 5'd21) return "R5";
    return "R6";
  endfunction

  // Called just after a falling edge with inputs set; checks, then advances model.
  task automatic tick();
    bit exp_ready, acc, pop;
    #1;
    exp_ready = !(wr_is_cop && m_q.size() >= 2);
    chk("R8", "wr_ready", {31'd0, wr_ready}, {31'd0, exp_ready});
    chk("R7", "to_host_valid", {31'd0, to_host_valid}, {31'd0, m_q.size() != 0});
    if (m_q.size() != 0) begin
      chk("R7", "to_host_idx", {27'd0, to_host_idx}, {27'd0, m_q[0][36:32]});
      chk("R9", "to_host_data", to_host_data, m_q[0][31:0]);
    end
    chk(read_req(rd_is_cop, rd_idx), "rd_data", rd_data, exp_read(rd_is_cop, rd_idx));
    chk("R2", "core_run", {31'd0, core_run}, {31'd0, m_run});
    if (m_run) chk("R2", "core_start_pc", core_start_pc, m_pc);
    acc = wr_valid && exp_ready;
    pop = (m_q.size() != 0) && to_host_ready;
    if (pop) void'(m_q.pop_front());
    if (acc && wr_is_cop) m_q.push_back({wr_idx, wr_data});
    if (acc && wr_is_cop && wr_idx == 5'd21) m_res = wr_data;
    if (host_start) begin
      m_cyc = 0; m_ins = 0; m_run = 1; m_pc = host_start_pc;
    end else begin
      if (m_run) m_cyc = m_cyc + 1;
      if (acc)   m_ins = m_ins + 1;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    host_start = 0; host_start_pc = 0; rd_is_cop = 0; rd_idx = 0;
    wr_valid = 0; wr_is_cop = 0; wr_idx = 0; wr_data = 0; to_host_ready = 0;
  endtask

  function automatic logic [4:0] pick_idx();
    case ($urandom % 4)
      0: return 5'd10;
      1: return 5'd11;
      2: return 5'd21;
      default: return 5'($urandom % 32);
    endcase
  endfunction

  task automatic rand_cycle(int ready_pct, int start_per_mille);
    rd_is_cop     = ($urandom % 8) != 0;
    rd_idx        = pick_idx();
    wr_valid      = ($urandom % 3) != 0;
    wr_is_cop     = ($urandom % 4) != 0;
    wr_idx        = pick_idx();
    wr_data       = $urandom;
    to_host_ready = int'($urandom % 100) < ready_pct;
    host_start    = int'($urandom % 1000) < start_per_mille;
    host_start_pc = $urandom;
    tick();
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired before completion");
    report();
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'h5eed_c0de);
    idle_inputs();
    m_run = 0; m_pc = 0; m_cyc = 0; m_ins = 0; m_res = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state of all three live slots and the handshakes
    for (int k = 0; k < 3; k++) begin
      rd_is_cop = 1;
      rd_idx = (k == 0) ? 5'd10 : (k == 1) ? 5'd11 : 5'd21;
      #1;
      chk("R1", "reset read", rd_data, 32'd0);
      chk("R1", "reset to_host_valid", {31'd0, to_host_valid}, 32'd0);
      chk("R1", "reset wr_ready", {31'd0, wr_ready}, 32'd1);
      chk("R1", "reset core_run", {31'd0, core_run}, 32'd0);
      tick();
    end

    // R3: cycle counter idle before start; random traffic without start
    for (int i = 0; i < 20; i++) rand_cycle(50, 0);

    // R2: directed start
    idle_inputs();
    host_start = 1; host_start_pc = 32'h0000_1000;
    tick();
    idle_inputs();
    rd_is_cop = 1; rd_idx = 5'd10;
    tick();  // reads 0 right after the start edge
    tick();  // reads 1

    // R8: directed fill with host stalled, then a normal write passes
    idle_inputs();
    wr_valid = 1; wr_is_cop = 1; wr_idx = 5'd21; wr_data = 32'hCAFE_0001;
    tick();
    wr_idx = 5'd3; wr_data = 32'hCAFE_0002;
    tick();
    wr_idx = 5'd7; wr_data = 32'hCAFE_0003;
    #1 chk("R8", "stall when queue full", {31'd0, wr_ready}, 32'd0);
    tick();
    wr_is_cop = 0;
    #1 chk("R8", "normal write not stalled", {31'd0, wr_ready}, 32'd1);
    tick();
    // R9: hold while blocked, then drain with a pop
    idle_inputs();
    rd_is_cop = 1; rd_idx = 5'd21;
    tick();
    to_host_ready = 1;
    tick();
    tick();
    rd_idx = 5'd11;
    tick();

    // Random mix: stalled host, free host, restarts
    for (int i = 0; i < 1500; i++) rand_cycle(15, 3);
    for (int i = 0; i < 1500; i++) rand_cycle(70, 5);

    // R4: start colliding with an accepted write clears the count
    idle_inputs();
    to_host_ready = 1;
    tick(); tick(); tick();
    host_start = 1; host_start_pc = 32'h0040_0000;
    wr_valid = 1; wr_is_cop = 0;
    tick();
    idle_inputs();
    rd_is_cop = 1; rd_idx = 5'd11;
    #1 chk("R4", "start beats write", rd_data, 32'd0);
    tick();

    report();
  end
endmodule